// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block keeps a five-stage in-order pipeline's traps precise. Each of the IF, ID, EX and MEM stage slots carries a valid bit, the instruction's PC, an exception flag and a 4-bit cause. A fault seen in a stage is only noted on the instruction that caused it. Nothing changes the fetch path until that instruction reaches the single commit point at the end of MEM. Faults are therefore taken in program order, whatever the order in which the stages detected them.

A trap is taken at commit. It is triggered by a flagged instruction, by an enabled external interrupt or by a non-maskable interrupt. Taking it saves the committing PC and the cause, steers fetch to a fixed handler address, squashes every younger instruction and stops the committing one from writing back. It also masks maskable interrupts and enters kernel mode. A return request steers fetch back to the saved PC, so the faulting instruction runs again. It also re-enables interrupts and drops back to user mode. Decode, the ALU, memory and the handler code lie outside the block. They appear only as raise inputs and as the redirect, flush and write-back outputs.

Top module: `exc_commit_unit`

## Requirements
- R1: After reset, intEnable is 1, kernelMode is 0, epc and trapCause are 0, every stage slot is empty, and redirect, flush and wbValid are 0.
- R2: Bit k of raiseIn and bits [4k+3:4k] of causeIn apply to the instruction held in stage k, where 0 = IF, 1 = ID, 2 = EX and 3 = MEM. A raise only marks that instruction. No redirect happens until that instruction is at commit (stage 3).
- R3: Traps are taken in program order. When instruction N is at commit with a fault (MEM raise, cause 5) and instruction N+1 gets an EX raise (cause 3) in the same cycle, the trap records cause 5 and epc = PC of N.
- R4: When one instruction is flagged in more than one stage, the cause from the earliest stage is kept. An ID raise with cause 2 followed by a MEM raise with cause 4 gives trapCause 2.
- R5: A trap is taken when there is an enabled external interrupt (extIrq with intEnable = 1) or an nmi while a valid instruction is at commit. It overrides any fault on that instruction. The recorded cause is 1 for nmi, which beats extIrq, and 0 for the external interrupt. Instruction causes are 2 = illegal opcode, 3 = overflow, 4 = misaligned, 5 = page fault.
- R6: In the cycle a trap is taken, redirect is 1 and redirectPc equals HANDLER (default 32'h0000_0080). On the next edge epc takes the committing instruction's PC.
- R7: flush is 1 for exactly the cycle of each trap or return. It empties IF, ID and EX, and the fetch input of that cycle is dropped. The committing instruction does not assert wbValid.
- R8: After a trap, intEnable is 0, kernelMode is 1 and trapCause holds the cause.
- R9: A return (rfe) without a trap gives redirect = 1 and redirectPc = epc, and it flushes every slot including commit. After it, intEnable is 1 and kernelMode is 0.
- R10: When intEnable is 0, extIrq has no effect: there is no redirect and the instruction at commit writes back. An nmi is still taken.
- R11: While stall is 1, the slots hold their state and raises are still recorded. No trap is taken and wbValid is 0. When stall is 1 and there is no flush, wbPc keeps its value.
- R12: If rfe and a trap come in the same cycle, the trap wins: redirectPc is HANDLER, kernelMode stays 1 and epc takes the commit PC.
- R13: An interrupt waits while the commit slot is empty, for example right after a flush. It causes no redirect in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze the stage slots |
| fetchValid | input | 1 | A new instruction enters IF |
| fetchPc | input | PW | PC of the entering instruction |
| raiseIn | input | 4 | Per-stage fault raise, bit k = stage k |
| causeIn | input | 16 | Per-stage cause, bits [4k+3:4k] |
| extIrq | input | 1 | Maskable external interrupt |
| nmi | input | 1 | Non-maskable interrupt |
| rfe | input | 1 | Return-from-exception request |
| redirect | output | 1 | Fetch must load redirectPc |
| redirectPc | output | PW | Handler address or saved PC |
| flush | output | 1 | Squash younger instructions |
| wbValid | output | 1 | Commit instruction writes back |
| wbPc | output | PW | PC of the instruction at commit |
| epc | output | PW | Saved exception PC |
| trapCause | output | 4 | Cause of the last trap |
| intEnable | output | 1 | Maskable interrupt enable |
| kernelMode | output | 1 | 1 while in kernel mode |

## Verification
The properties assume that causeIn carries only codes 2 to 5 wherever the matching raise bit is set. They also assume that nmi, extIrq and rfe are one-cycle or short requests rather than levels held for the whole run. The random stimulus picks causes only from that set, and it asserts nmi, extIrq, rfe and the raises in a small fraction of cycles while keeping fetch busy. This lets faults, interrupts and returns fall on full, stalled and freshly flushed pipelines. Directed steps then place the ordering and collision cases on exact cycles.

// File: rtl/exc_commit_pkg.sv
package exc_commit_pkg;
  localparam int CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_EXT      = 4'd0,
    CAUSE_NMI      = 4'd1,
    CAUSE_ILLEGAL  = 4'd2,
    CAUSE_OVF      = 4'd3,
    CAUSE_MISALIGN = 4'd4,
    CAUSE_PAGE     = 4'd5
  } cause_e;

  typedef struct packed {
    logic               takeTrap;
    logic               takeReturn;
    logic               squash;
    logic               advance;
    logic [CAUSE_W-1:0] causeSel;
  } strobe_t;
endpackage

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_commit_pkg::*;
#(
  parameter int            PW      = 32,
  parameter int            NSTAGE  = 4,
  parameter logic [PW-1:0] HANDLER = 32'h0000_0080
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic                  fetchValid,
  input  logic [PW-1:0]         fetchPc,
  input  logic [NSTAGE-1:0]     raiseIn,
  input  logic [NSTAGE*CAUSE_W-1:0] causeIn,
  output logic                  commitValid,
  output logic                  commitFlag,
  output logic [CAUSE_W-1:0]    commitCause,
  output logic [PW-1:0]         commitPc,
  output logic [PW-1:0]         redirectPc,
  output logic [PW-1:0]         epc,
  output logic [CAUSE_W-1:0]    trapCause
);
  localparam int CW   = CAUSE_W;
  localparam int LAST = NSTAGE - 1;

  logic [NSTAGE-1:0] vld, flg, effFlag, prevV, prevF;
  logic [CW-1:0]     cse[NSTAGE];
  logic [CW-1:0]     effCause[NSTAGE];
  logic [CW-1:0]     prevC[NSTAGE];
  logic [PW-1:0]     pcs[NSTAGE];
  logic [PW-1:0]     prevPc[NSTAGE];

  generate
    for (genvar k = 0; k < NSTAGE; k++) begin : g_slot
      // first recorded cause sticks; later stages only fill an empty flag
      assign effFlag[k]  = flg[k] | (vld[k] & raiseIn[k]);
      assign effCause[k] = flg[k] ? cse[k] : causeIn[k*CW +: CW];
      if (k == 0) begin : g_head
        assign prevV[k]  = fetchValid;
        assign prevF[k]  = 1'b0;
        assign prevC[k]  = '0;
        assign prevPc[k] = fetchPc;
      end else begin : g_body
        assign prevV[k]  = vld[k-1];
        assign prevF[k]  = effFlag[k-1];
        assign prevC[k]  = effCause[k-1];
        assign prevPc[k] = pcs[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NSTAGE; k++) begin
        vld[k] <= 1'b0;
        flg[k] <= 1'b0;
        cse[k] <= '0;
        pcs[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NSTAGE; k++) begin
        if (strobe.squash) begin
          vld[k] <= 1'b0;
          flg[k] <= 1'b0;
        end else if (strobe.advance) begin
          vld[k] <= prevV[k];
          flg[k] <= prevF[k];
          cse[k] <= prevC[k];
          pcs[k] <= prevPc[k];
        end else begin
          flg[k] <= effFlag[k];
          cse[k] <= effCause[k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      epc       <= '0;
      trapCause <= '0;
    end else if (strobe.takeTrap) begin
      epc       <= pcs[LAST];
      trapCause <= strobe.causeSel;
    end
  end

  assign commitValid = vld[LAST];
  assign commitFlag  = effFlag[LAST];
  assign commitCause = effCause[LAST];
  assign commitPc    = pcs[LAST];
  assign redirectPc  = strobe.takeReturn ? epc : HANDLER;
endmodule

// File: rtl/exc_control.sv
module exc_control
  import exc_commit_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  logic               extIrq,
  input  logic               nmi,
  input  logic               rfe,
  input  logic               commitValid,
  input  logic               commitFlag,
  input  logic [CAUSE_W-1:0] commitCause,
  output strobe_t            strobe,
  output logic               wbValid,
  output logic               intEnable,
  output logic               kernelMode
);
  logic irqOn, trapNow, retNow;

  assign irqOn   = extIrq & intEnable;
  assign trapNow = !stall && commitValid && (nmi || irqOn || commitFlag);
  assign retNow  = rfe && !trapNow;

  always_comb begin
    strobe.takeTrap   = trapNow;
    strobe.takeReturn = retNow;
    strobe.squash     = trapNow | retNow;
    strobe.advance    = !stall;
    if (nmi)        strobe.causeSel = CAUSE_NMI;
    else if (irqOn) strobe.causeSel = CAUSE_EXT;
    else            strobe.causeSel = commitCause;
  end

  assign wbValid = commitValid && !stall && !strobe.squash;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnable  <= 1'b1;
      kernelMode <= 1'b0;
    end else if (trapNow) begin
      intEnable  <= 1'b0;
      kernelMode <= 1'b1;
    end else if (retNow) begin
      intEnable  <= 1'b1;
      kernelMode <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_commit_pkg::*;
#(
  parameter int            PW      = 32,
  parameter logic [PW-1:0] HANDLER = 32'h0000_0080
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stall,
  input  logic          fetchValid,
  input  logic [PW-1:0] fetchPc,
  input  logic [3:0]    raiseIn,
  input  logic [15:0]   causeIn,
  input  logic          extIrq,
  input  logic          nmi,
  input  logic          rfe,
  output logic          redirect,
  output logic [PW-1:0] redirectPc,
  output logic          flush,
  output logic          wbValid,
  output logic [PW-1:0] wbPc,
  output logic [PW-1:0] epc,
  output logic [3:0]    trapCause,
  output logic          intEnable,
  output logic          kernelMode
);
  strobe_t            strobe;
  logic               commitValid, commitFlag;
  logic [CAUSE_W-1:0] commitCause;

  exc_datapath #(.PW(PW), .NSTAGE(4), .HANDLER(HANDLER)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fetchValid(fetchValid), .fetchPc(fetchPc),
    .raiseIn(raiseIn), .causeIn(causeIn),
    .commitValid(commitValid), .commitFlag(commitFlag),
    .commitCause(commitCause), .commitPc(wbPc),
    .redirectPc(redirectPc), .epc(epc), .trapCause(trapCause)
  );

  exc_control u_ctl (
    .clk(clk), .rstN(rstN), .stall(stall), .extIrq(extIrq), .nmi(nmi),
    .rfe(rfe), .commitValid(commitValid), .commitFlag(commitFlag),
    .commitCause(commitCause), .strobe(strobe), .wbValid(wbValid),
    .intEnable(intEnable), .kernelMode(kernelMode)
  );

  assign redirect = strobe.takeTrap | strobe.takeReturn;
  assign flush    = strobe.squash;
endmodule

// File: rtl/exc_commit_checker.sv
module exc_commit_checker
  import exc_commit_pkg::*;
#(
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rstN,
  input strobe_t       strobe,
  input logic          rfe,
  input logic          stall,
  input logic          flush,
  input logic          wbValid,
  input logic [PW-1:0] wbPc,
  input logic [PW-1:0] epc,
  input logic [3:0]    trapCause,
  input logic          intEnable,
  input logic          kernelMode
);
  assert_trap_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeTrap |=> kernelMode && !intEnable && trapCause == $past(strobe.causeSel));

  assert_epc_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeTrap |=> epc == $past(wbPc));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !wbValid);

  assert_masked_not_ext_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeTrap && !intEnable |=> trapCause != 4'd0);

  assert_return_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeReturn |=> !kernelMode && intEnable);

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    stall && !flush |=> wbPc == $past(wbPc));

  assert_trap_beats_rfe_R12: assert property (@(posedge clk) disable iff (!rstN)
    rfe && strobe.takeTrap |=> kernelMode);
endmodule

bind exc_commit_unit exc_commit_checker #(.PW(PW)) u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .rfe(rfe), .stall(stall),
  .flush(flush), .wbValid(wbValid), .wbPc(wbPc), .epc(epc),
  .trapCause(trapCause), .intEnable(intEnable), .kernelMode(kernelMode)
);

// File: tb/sim_exc_commit_unit.sv
module sim_exc_commit_unit;
  localparam logic [31:0] HANDLER = 32'h0000_0080;

  logic clk = 1'b0, rstN = 1'b0;
  logic stall = 0, fetchValid = 0, extIrq = 0, nmi = 0, rfe = 0;
  logic [31:0] fetchPc = 0;
  logic [3:0]  raiseIn = 0;
  logic [15:0] causeIn = 0;
  logic redirect, flush, wbValid, intEnable, kernelMode;
  logic [31:0] redirectPc, wbPc, epc;
  logic [3:0]  trapCause;

  always #10 clk = ~clk;

  exc_commit_unit #(.PW(32), .HANDLER(HANDLER)) u0 (.*);

  int checks = 0, fails = 0;
  logic [31:0] nextPc = 32'h1000;
  logic mv[4], mf[4];
  logic [3:0] mc[4];
  logic [31:0] mp[4];
  logic mie = 1, mk = 0;
  logic [31:0] mepc = 0;
  logic [3:0] mcause = 0;
  logic sRedirect, sWb;
  logic [31:0] sRedirectPc, savedPc;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic fv, logic [3:0] r, logic [15:0] c,
                      logic st, logic irq, logic n, logic rf);
    logic ef[4];
    logic [3:0] ec[4];
    logic trap, ret, eWb;
    @(negedge clk);
    fetchValid = fv; fetchPc = nextPc; raiseIn = r; causeIn = c;
    stall = st; extIrq = irq; nmi = n; rfe = rf;
    #1;
    for (int k = 0; k < 4; k++) begin
      ef[k] = mf[k] | (mv[k] & r[k]);
      ec[k] = mf[k] ? mc[k] : c[k*4 +: 4];
    end
    trap = !st && mv[3] && (n || (irq && mie) || ef[3]);
    ret  = rf && !trap;
    eWb  = mv[3] && !st && !trap && !ret;
    sRedirect = redirect; sRedirectPc = redirectPc; sWb = wbValid;
    check("R6 redirect", {31'b0, redirect}, {31'b0, trap || ret});
    if (trap) check("R6 redirectPc", redirectPc, HANDLER);
    else if (ret) check("R9 redirectPc", redirectPc, mepc);
    check("R7 flush", {31'b0, flush}, {31'b0, trap || ret});
    check("R11 wbValid", {31'b0, wbValid}, {31'b0, eWb});
    if (eWb) check("R3 wbPc", wbPc, mp[3]);
    if (trap) begin
      mepc = mp[3];
      mcause = n ? 4'd1 : (irq && mie) ? 4'd0 : ec[3];
      mie = 0; mk = 1;
    end else if (ret) begin
      mie = 1; mk = 0;
    end
    if (trap || ret) begin
      for (int k = 0; k < 4; k++) begin mv[k] = 0; mf[k] = 0; end
    end else if (st) begin
      for (int k = 0; k < 4; k++) begin mf[k] = ef[k]; mc[k] = ec[k]; end
    end else begin
      for (int k = 3; k > 0; k--) begin
        mv[k] = mv[k-1]; mf[k] = ef[k-1]; mc[k] = ec[k-1]; mp[k] = mp[k-1];
      end
      mv[0] = fv; mf[0] = 0; mc[0] = 0; mp[0] = nextPc;
    end
    nextPc += 4;
    @(posedge clk); #1;
    check("R6 epc", epc, mepc);
    check("R8 trapCause", {28'b0, trapCause}, {28'b0, mcause});
    check("R8 intEnable", {31'b0, intEnable}, {31'b0, mie});
    check("R8 kernelMode", {31'b0, kernelMode}, {31'b0, mk});
  endtask

  task automatic plain(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finishRun();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin mv[k] = 0; mf[k] = 0; mc[k] = 0; mp[k] = 0; end
    void'($urandom(32'd24680));
    #35;
    check("R1 intEnable", {31'b0, intEnable}, 32'd1);
    check("R1 kernelMode", {31'b0, kernelMode}, 32'd0);
    check("R1 epc", epc, 32'd0);
    check("R1 trapCause", {28'b0, trapCause}, 32'd0);
    check("R1 redirect", {31'b0, redirect | flush | wbValid}, 32'd0);
    @(negedge clk); rstN = 1;

    // R3: MEM page fault of N against EX overflow of N+1
    plain(4);
    savedPc = nextPc - 16;
    step(1, 4'b1100, 16'h5300, 0, 0, 0, 0);
    check("R3 trap taken", {31'b0, sRedirect}, 32'd1);
    check("R3 cause", {28'b0, trapCause}, 32'd5);
    check("R3 epc", epc, savedPc);
    step(1, 0, 0, 0, 0, 0, 1);
    check("R9 return pc", sRedirectPc, savedPc);
    check("R9 mode", {30'b0, intEnable, kernelMode}, 32'd2);
    // R13: commit slot empty after flush
    step(1, 0, 0, 0, 1, 0, 0);
    check("R13 no redirect", {31'b0, sRedirect}, 32'd0);

    // R2 and R4: ID raise then MEM raise on the same instruction
    plain(4);
    step(1, 4'b0010, 16'h0020, 0, 0, 0, 0);
    check("R2 no early redirect", {31'b0, sRedirect}, 32'd0);
    step(1, 0, 0, 0, 0, 0, 0);
    check("R2 no early redirect", {31'b0, sRedirect}, 32'd0);
    savedPc = nextPc - 16;
    step(1, 4'b1000, 16'h4000, 0, 0, 0, 0);
    check("R4 cause kept", {28'b0, trapCause}, 32'd2);
    check("R4 epc", epc, savedPc);

    // R10: masked extIrq ignored, nmi taken
    plain(4);
    step(1, 0, 0, 0, 1, 0, 0);
    check("R10 masked irq", {31'b0, sRedirect}, 32'd0);
    check("R10 wb continues", {31'b0, sWb}, 32'd1);
    step(1, 0, 0, 0, 0, 1, 0);
    check("R10 nmi cause", {28'b0, trapCause}, 32'd1);

    // R12: rfe collides with a trap
    plain(4);
    step(1, 4'b1000, 16'h3000, 0, 0, 0, 1);
    check("R12 redirectPc", sRedirectPc, HANDLER);
    check("R12 kernel", {31'b0, kernelMode}, 32'd1);
    check("R12 cause", {28'b0, trapCause}, 32'd3);
    step(1, 0, 0, 0, 0, 0, 1);

    // R5: enabled interrupt overrides pending fault
    plain(4);
    step(1, 4'b1000, 16'h5000, 0, 1, 0, 0);
    check("R5 ext cause", {28'b0, trapCause}, 32'd0);
    step(1, 0, 0, 0, 0, 0, 1);

    // R11: raise while stalled, taken after release
    plain(4);
    step(1, 4'b1000, 16'h4000, 1, 0, 0, 0);
    check("R11 stalled no trap", {31'b0, sRedirect | sWb}, 32'd0);
    step(1, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    check("R11 latched cause", {28'b0, trapCause}, 32'd4);
    step(1, 0, 0, 0, 0, 0, 1);

    // random mix, all checked by the model (R2 R3 R5 R7 R11)
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      logic [15:0] c;
      for (int k = 0; k < 4; k++) begin
        r[k] = ($urandom % 100) < 3;
        c[k*4 +: 4] = 4'(2 + $urandom % 4);
      end
      step(($urandom % 100) < 80, r, c, ($urandom % 100) < 15,
           ($urandom % 100) < 3, ($urandom % 100) < 1, ($urandom % 100) < 3);
    end
    finishRun();
  end
endmodule